// File: doc/BRIEF.md
# Periodic Wakeup Interrupt Timer

This block raises a wakeup event at a fixed, selectable rate. A free-running divider counts cycles of the block clock. A three-bit select code picks one of seven divider taps, and each tap has twice the period of the one before it. When the chosen period has elapsed, a sticky status flag is set. The interrupt line is asserted while that flag and a local enable are both set.

Software controls the block through one 8-bit control/status register. A select code of zero stops the divider, so no new events occur. Software clears the flag by writing one to a separate acknowledge bit. That bit always reads back as zero. Writing the flag bit itself has no effect. Writing a select code that differs from the current one restarts the divider from zero.

Top module: `wakeup_timer`

## Requirements
- R1: After reset the register reads 0x00 and `irq` is low, so the timer starts disabled.
- R2: The register has this layout: bit 7 is the flag (read-only), bit 4 is the enable, and bits 2:0 are the select code. Bits 6, 5 and 3 read as 0. Writing bit 7 never changes the flag.
- R3: Writing 1 to bit 6 (the acknowledge bit) clears the flag at that clock edge. If a period expires in the same cycle, the flag stays set.
- R4: For select code k in 1..7, the flag is set every 2^(BASE_LOG2+k-1) clock cycles. The first set happens that many cycles after the edge that wrote k. With BASE_LOG2=2, code 1 gives 4 cycles and code 7 gives 256 cycles.
- R5: `irq` equals flag AND enable. The enable does not affect whether the flag is set.
- R6: With select code 0 the flag is never newly set. A flag that is already set stays set until it is acknowledged.
- R7: A write whose select code differs from the current one restarts the count from zero, and a period ending in that cycle is discarded. A write with the same code leaves the count running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, also the timing clock that is divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `reg_wr` and `reg_wdata` are settled at every rising edge and never unknown once reset is released. The bench drives both only just after an edge and gives them defined values on every cycle, including idle cycles. It keeps random select changes rare, so that the longer periods complete between writes and the window checks can see real expiries.

// File: rtl/wkt_pkg.sv
package wkt_pkg;

    localparam int REG_W    = 8;
    localparam int SEL_W    = 3;
    localparam int NUM_CODE = (1 << SEL_W) - 1;

    // register bit positions
    localparam int FLAG_BIT = 7;
    localparam int ACK_BIT  = 6;
    localparam int EN_BIT   = 4;
    localparam int SEL_LSB  = 0;

    typedef logic [SEL_W-1:0] sel_t;

    typedef struct packed {
        logic flag;
        logic en;
        sel_t sel;
    } ctrl_t;

endpackage

// File: rtl/wkt_divider.sv
module wkt_divider
    import wkt_pkg::*;
#(
    parameter int BASE_LOG2 = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  sel_t sel,
    input  logic restart,
    output logic expire
);
    localparam int CNT_W = BASE_LOG2 + NUM_CODE - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;
    logic [CNT_W-1:0] term [0:NUM_CODE];
    logic hit;

    // terminal count per select code, each tap doubling the previous one
    for (genvar g = 0; g <= NUM_CODE; g++) begin : g_term
        if (g == 0) begin : g_off
            assign term[g] = '0;
        end else begin : g_tap
            assign term[g] = {CNT_W{1'b1}} >> (NUM_CODE - g);
        end
    end

    always_comb begin
        st_d   = st_q;
        hit    = (sel != '0) && (st_q.cnt == term[sel]);
        expire = hit && !restart;
        if (restart || sel == '0 || hit) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q.cnt == '0)); // R7

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= term[sel]); // R4

endmodule

// File: rtl/wkt_regs.sv
module wkt_regs
    import wkt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    input  logic             expire,
    output sel_t             sel_q,
    output logic             en_q,
    output logic             flag_q,
    output logic             restart,
    output logic [REG_W-1:0] rdata
);
    ctrl_t ctrl_d, ctrl_q;
    sel_t  wsel;
    logic  ack;

    always_comb begin
        wsel    = wdata[SEL_LSB +: SEL_W];
        ack     = wr_en && wdata[ACK_BIT];
        restart = wr_en && (wsel != ctrl_q.sel);
        ctrl_d  = ctrl_q;
        if (wr_en) begin
            ctrl_d.sel = wsel;
            ctrl_d.en  = wdata[EN_BIT];
        end
        ctrl_d.flag = (ctrl_q.flag && !ack) || expire;

        rdata                      = '0;
        rdata[FLAG_BIT]            = ctrl_q.flag;
        rdata[EN_BIT]              = ctrl_q.en;
        rdata[SEL_LSB +: SEL_W]    = ctrl_q.sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign sel_q  = ctrl_q.sel;
    assign en_q   = ctrl_q.en;
    assign flag_q = ctrl_q.flag;

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata[ACK_BIT] && !expire) |=> !ctrl_q.flag); // R3

    AST_EXPIRE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> ctrl_q.flag); // R3

    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!expire && !(wr_en && wdata[ACK_BIT])) |=> $stable(ctrl_q.flag)); // R2

endmodule

// File: rtl/wakeup_timer.sv
module wakeup_timer
    import wkt_pkg::*;
#(
    parameter int BASE_LOG2 = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq
);
    sel_t sel;
    logic en, flag, restart, expire;

    wkt_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .wdata   (reg_wdata),
        .expire  (expire),
        .sel_q   (sel),
        .en_q    (en),
        .flag_q  (flag),
        .restart (restart),
        .rdata   (reg_rdata)
    );

    wkt_divider #(.BASE_LOG2(BASE_LOG2)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .restart (restart),
        .expire  (expire)
    );

    assign irq = flag && en;

    AST_OFF_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == '0) |=> !$rose(flag)); // R6

endmodule

// File: tb/sim_wakeup_timer.sv
`timescale 1ns/1ps
module sim_wakeup_timer;
    localparam int B = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wd = 8'h00;
    logic [7:0] rdata;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [2:0] ref_sel = 3'd0;
    logic       ref_en = 1'b0;
    logic       ref_flag = 1'b0;
    int         ref_cnt = 0;

    always #2.5 clk = ~clk;

    wakeup_timer #(.BASE_LOG2(B)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(wr), .reg_wdata(wd),
        .reg_rdata(rdata), .irq(irq)
    );

    function automatic int last_of(input logic [2:0] s);
        return (1 << (B + int'(s) - 1)) - 1;
    endfunction

    function automatic logic [7:0] exp_reg();
        return {ref_flag, 2'b00, ref_en, 1'b0, ref_sel};
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic step(input logic w, input logic [7:0] d, input string tag);
        logic chg, hit, ex;
        wr = w;
        wd = d;
        chg = w && (d[2:0] != ref_sel);
        hit = (ref_sel != 3'd0) && (ref_cnt == last_of(ref_sel));
        ex  = hit && !chg;
        ref_flag = (ref_flag && !(w && d[6])) || ex;
        if (chg || ref_sel == 3'd0 || hit) ref_cnt = 0;
        else ref_cnt = ref_cnt + 1;
        if (w) begin
            ref_sel = d[2:0];
            ref_en  = d[4];
        end
        @(posedge clk);
        #1;
        wr = 1'b0;
        wd = 8'h00;
        check(tag, rdata, exp_reg());
        check({tag, " irq"}, {7'd0, irq}, {7'd0, ref_flag && ref_en});
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 8'h00, tag);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got hung expected finish");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'h5EED));
        #12;
        check("R1 reset", rdata, 8'h00);
        check("R1 reset irq", {7'd0, irq}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1", rdata, 8'h00);

        // R4: code 1 with enable, flag after 4 cycles
        step(1'b1, 8'h11, "R4");
        idle(10, "R4");
        // R3: acknowledge in the cycle where the period ends keeps the flag
        while (ref_cnt != last_of(ref_sel)) step(1'b0, 8'h00, "R3");
        step(1'b1, 8'h51, "R3 collide");
        step(1'b1, 8'h51, "R3 ack");
        // R2: writing the flag bit and reserved bits has no effect on flag
        step(1'b1, 8'hA9, "R2");
        idle(3, "R2");
        step(1'b1, 8'hB1, "R2 flag write");
        // R5: enable off, flag still sets, irq low
        step(1'b1, 8'h42, "R5");
        idle(12, "R5");
        step(1'b1, 8'h12, "R5 enable");
        // R6: select zero, no new sets, existing flag kept
        step(1'b1, 8'h10, "R6");
        idle(300, "R6");
        step(1'b1, 8'h50, "R6 ack");
        idle(20, "R6");
        // R7: restart on changed code, continue on same code
        step(1'b1, 8'h13, "R7");
        idle(20, "R7");
        step(1'b1, 8'h13, "R7 same");
        idle(5, "R7");
        step(1'b1, 8'h12, "R7 change");
        idle(20, "R7");
        // R4: every code
        for (int k = 1; k <= 7; k++) begin
            step(1'b1, 8'h50 | 8'(k), "R4 code");
            idle(2 * (1 << (B + k - 1)) + 3, "R4 code");
        end
        // random mix
        for (int i = 0; i < 6000; i++) begin
            if ($urandom % 25 == 0) begin
                d = 8'($urandom);
                if ($urandom % 4 != 0) d[2:0] = ref_sel;
                step(1'b1, d, "R3 R4 R5 R7 rand");
            end else begin
                step(1'b0, 8'($urandom), "R4 rand idle");
            end
        end
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule